// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Engine

This block fronts a small shared word memory and serves several requesting agents through one engine. Each agent has a valid/ready request channel carrying an opcode, a word address, a data operand and a compare operand. It also has a response lane of its own, carrying the prior memory word and a success bit. A round-robin arbiter picks one requester at a time. Once an agent is picked, the engine reads the addressed word in the grant cycle and writes the result in the next cycle. No other agent is accepted between that read and that write, so every operation is indivisible with respect to all other agents.

The engine supports plain load and plain store, and four atomic primitives: test-and-set, swap, compare-and-swap and fetch-and-increment. A word value of zero stands for a free lock and any non-zero value stands for a held lock. Software therefore acquires with test-and-set or compare-and-swap and releases with a plain store of zero. Counters and tickets use fetch-and-increment.

Top module: `rmw_atomic_unit`

## Requirements
- R1: While reset is asserted and after it is released, every memory word reads zero, `reqReady` is all zero while no request is valid, and `rspValid` is all zero until a request has been accepted.
- R2: `reqReady` has at most one bit set, and only for an agent whose `reqValid` is high. The pick scans agents upward, wrapping, starting just after the agent accepted last. After reset the scan starts at agent 0.
- R3: In the cycle after an acceptance no agent is accepted. The read and the write of one operation therefore fill two back-to-back cycles with no access by another agent between them.
- R4: A request accepted at clock edge k raises `rspValid` on that agent's lane only, for the single cycle following edge k+1. `rspData` carries the memory word as it was before the operation.
- R5: Opcode 0 (load) and the unused opcodes 6 and 7 return the word and leave memory unchanged, with `rspOk` = 1.
- R6: Opcode 1 (store) writes the data operand and returns the old word with `rspOk` = 1. A store of zero to a lock word frees it, so a following test-and-set on that word returns 0.
- R7: Opcode 2 (test-and-set) returns the old word and writes 1. When several agents test-and-set one free word, exactly one of them gets 0.
- R8: Opcode 3 (swap) writes the data operand and returns the old word, with `rspOk` = 1.
- R9: Opcode 4 (compare-and-swap) writes the data operand only when the old word equals the compare operand. `rspOk` is 1 when it wrote and 0 when it did not, and the old word is returned either way.
- R10: Opcode 5 (fetch-and-increment) returns the old word and stores it plus one modulo 2^W, so all-ones becomes zero.
- R11: The responses to one agent come back in the order in which that agent's requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | AGENTS | Per-agent request valid |
| reqReady | output | AGENTS | Per-agent request accepted this cycle |
| reqOp | input | AGENTS*3 | Per-agent opcode, 3 bits each |
| reqAddr | input | AGENTS*AW | Per-agent word address |
| reqData | input | AGENTS*W | Per-agent data operand (store, swap, compare-and-swap new value) |
| reqCmp | input | AGENTS*W | Per-agent compare operand for compare-and-swap |
| rspValid | output | AGENTS | Per-agent one-cycle response strobe |
| rspData | output | AGENTS*W | Per-agent prior memory word |
| rspOk | output | AGENTS | Per-agent success bit |

## Verification
The hardest situation to reach from the ports is true contention: several agents racing test-and-set or fetch-and-increment on one word, with a new request arriving in the same cycle an older one is still being written. The stimulus produces this in two ways. Directed bursts present all agents' requests in the same cycle. Random traffic is confined to four addresses and re-issues requests immediately after acceptance, so back-to-back grants, losing compare-and-swaps and in-order returns per agent occur constantly.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4,
    OP_FINC  = 3'd5
  } rmwOp_e;

  localparam int OP_BITS = 3;

  typedef struct packed {
    logic capture;  // latch granted request, start memory read
    logic modify;   // compute, write back, emit response
  } rmwStrobe_t;

endpackage

// File: rtl/rmw_rr_arbiter.sv
module rmw_rr_arbiter #(
  parameter int AGENTS = 4,
  localparam int IW = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AGENTS-1:0] reqVec,
  input  logic              enable,
  output logic [AGENTS-1:0] grantVec,
  output logic [IW-1:0]     grantIdx
);

  logic [IW-1:0] lastIdx;
  logic          found;

  always_comb begin
    found    = 1'b0;
    grantIdx = lastIdx;
    for (int k = 1; k <= AGENTS; k++) begin
      int cand;
      cand = (int'(lastIdx) + k) % AGENTS;
      if (!found && reqVec[cand]) begin
        found    = 1'b1;
        grantIdx = IW'(cand);
      end
    end
    grantVec = '0;
    if (found && enable) grantVec[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lastIdx <= IW'(AGENTS - 1);
    else if (|grantVec) lastIdx <= grantIdx;
  end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       anyGrant,
  output logic       idle,
  output rmwStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_MODIFY} state_e;
  state_e state, stateNext;

  always_comb begin
    idle           = (state == ST_IDLE);
    strobe.capture = idle && anyGrant;
    strobe.modify  = (state == ST_MODIFY);
    stateNext      = state;
    case (state)
      ST_IDLE:   if (anyGrant) stateNext = ST_MODIFY;
      ST_MODIFY: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int AGENTS = 4,
  parameter int W      = 32,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rmwStrobe_t              strobe,
  input  logic [IW-1:0]           grantIdx,
  input  logic [AGENTS*OP_BITS-1:0] reqOp,
  input  logic [AGENTS*AW-1:0]    reqAddr,
  input  logic [AGENTS*W-1:0]     reqData,
  input  logic [AGENTS*W-1:0]     reqCmp,
  output logic [AGENTS-1:0]       rspValid,
  output logic [AGENTS*W-1:0]     rspData,
  output logic [AGENTS-1:0]       rspOk
);

  logic [W-1:0]       memWords [DEPTH];
  logic [W-1:0]       oldWord;
  logic [IW-1:0]      curAgent;
  logic [OP_BITS-1:0] curOp;
  logic [AW-1:0]      curAddr;
  logic [W-1:0]       curData;
  logic [W-1:0]       curCmp;

  logic [AW-1:0] selAddr;
  logic [W-1:0]  newWord;
  logic          writeIt;
  logic          success;

  assign selAddr = reqAddr[grantIdx*AW +: AW];

  // Request capture and memory read in the grant cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      curAgent <= '0;
      curOp    <= '0;
      curAddr  <= '0;
      curData  <= '0;
      curCmp   <= '0;
    end else if (strobe.capture) begin
      curAgent <= grantIdx;
      curOp    <= reqOp[grantIdx*OP_BITS +: OP_BITS];
      curAddr  <= selAddr;
      curData  <= reqData[grantIdx*W +: W];
      curCmp   <= reqCmp[grantIdx*W +: W];
    end
  end

  // Modify rule per opcode.
  always_comb begin
    newWord = curData;
    writeIt = 1'b0;
    success = 1'b1;
    case (curOp)
      OP_STORE: writeIt = 1'b1;
      OP_TAS: begin
        writeIt = 1'b1;
        newWord = W'(1);
      end
      OP_SWAP: writeIt = 1'b1;
      OP_CAS: begin
        writeIt = (oldWord == curCmp);
        success = writeIt;
      end
      OP_FINC: begin
        writeIt = 1'b1;
        newWord = oldWord + W'(1);
      end
      default: writeIt = 1'b0;
    endcase
  end

  // Storage: read on capture, write on modify.
  always_ff @(posedge clk) begin
    if (rst) begin
      oldWord <= '0;
      for (int i = 0; i < DEPTH; i++) memWords[i] <= '0;
    end else begin
      if (strobe.capture) oldWord <= memWords[selAddr];
      if (strobe.modify && writeIt) memWords[curAddr] <= newWord;
    end
  end

  // One response lane per agent.
  for (genvar g = 0; g < AGENTS; g++) begin : gLane
    logic         laneValid;
    logic [W-1:0] laneData;
    logic         laneOk;
    logic         laneHit;

    assign laneHit = strobe.modify && (curAgent == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        laneValid <= 1'b0;
        laneData  <= '0;
        laneOk    <= 1'b0;
      end else begin
        laneValid <= laneHit;
        if (laneHit) begin
          laneData <= oldWord;
          laneOk   <= success;
        end
      end
    end

    assign rspValid[g]         = laneValid;
    assign rspData[g*W +: W]   = laneData;
    assign rspOk[g]            = laneOk;
  end

endmodule

// File: rtl/rmw_atomic_unit.sv
module rmw_atomic_unit
  import rmw_pkg::*;
#(
  parameter int AGENTS = 4,
  parameter int W      = 32,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AGENTS-1:0]     reqValid,
  output logic [AGENTS-1:0]     reqReady,
  input  logic [AGENTS*3-1:0]   reqOp,
  input  logic [AGENTS*AW-1:0]  reqAddr,
  input  logic [AGENTS*W-1:0]   reqData,
  input  logic [AGENTS*W-1:0]   reqCmp,
  output logic [AGENTS-1:0]     rspValid,
  output logic [AGENTS*W-1:0]   rspData,
  output logic [AGENTS-1:0]     rspOk
);

  localparam int IW = (AGENTS > 1) ? $clog2(AGENTS) : 1;

  logic          idle;
  logic [IW-1:0] grantIdx;
  rmwStrobe_t    strobe;

  rmw_rr_arbiter #(.AGENTS(AGENTS)) i_arb (
    .clk      (clk),
    .rst      (rst),
    .reqVec   (reqValid),
    .enable   (idle),
    .grantVec (reqReady),
    .grantIdx (grantIdx)
  );

  rmw_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .anyGrant (|reqReady),
    .idle     (idle),
    .strobe   (strobe)
  );

  rmw_datapath #(.AGENTS(AGENTS), .W(W), .DEPTH(DEPTH)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .grantIdx (grantIdx),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqCmp   (reqCmp),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspOk    (rspOk)
  );

endmodule

// File: rtl/rmw_atomic_chk.sv
module rmw_atomic_chk #(
  parameter int AGENTS = 4,
  parameter int W      = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [AGENTS-1:0] reqValid,
  input logic [AGENTS-1:0] reqReady,
  input logic [AGENTS-1:0] rspValid
);

  // R2: single grant, only to a requester
  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqReady));

  a_r2_grant_has_req: assert property (@(posedge clk) disable iff (rst)
    (reqReady & ~reqValid) == '0);

  // R3: memory held for read and write, nobody else accepted in between
  a_r3_exclusive_hold: assert property (@(posedge clk) disable iff (rst)
    (|reqReady) |=> (reqReady == '0));

  // R4: response lane and timing follow the acceptance
  a_r4_response_follows: assert property (@(posedge clk) disable iff (rst)
    (|reqReady) |=> ##1 (rspValid == $past(reqReady, 2)));

  a_r4_single_response: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rspValid));

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (|rspValid) |-> (rspValid == $past(reqReady, 2)));

endmodule

bind rmw_atomic_unit rmw_atomic_chk #(.AGENTS(AGENTS), .W(W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid)
);

// File: tb/test_rmw_atomic_unit.sv
module test_rmw_atomic_unit;

  localparam int NA = 4;
  localparam int W  = 32;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NA-1:0]   reqValid = '0;
  logic [NA-1:0]   reqReady;
  logic [NA*3-1:0] reqOp = '0;
  logic [NA*AW-1:0] reqAddr = '0;
  logic [NA*W-1:0] reqData = '0;
  logic [NA*W-1:0] reqCmp = '0;
  logic [NA-1:0]   rspValid;
  logic [NA*W-1:0] rspData;
  logic [NA-1:0]   rspOk;

  always #4 clk = ~clk;  // 125 MHz

  rmw_atomic_unit #(.AGENTS(NA), .W(W), .DEPTH(DEPTH)) i_rmw_atomic_unit (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .reqCmp(reqCmp),
    .rspValid(rspValid), .rspData(rspData), .rspOk(rspOk)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lastGrant = NA - 1;
  int lastAccCyc = -10;
  int randomLeft = 0;
  int tasZeroSeen = 0;
  bit countTas = 0;

  logic [W-1:0] model [DEPTH];

  // staged requests per agent
  bit         stHave [NA];
  logic [2:0] stOp   [NA];
  logic [AW-1:0] stAddr [NA];
  logic [W-1:0] stData [NA];
  logic [W-1:0] stCmp  [NA];
  string      stTag  [NA];
  bit         justAcc [NA];

  // pending expectations per agent (ring)
  logic [W-1:0] pData [NA][QD];
  logic         pOk   [NA][QD];
  int           pCyc  [NA][QD];
  logic [2:0]   pOpQ  [NA][QD];
  string        pTag  [NA][QD];
  int pHead [NA];
  int pCnt  [NA];

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R10";
      default: return "R5";
    endcase
  endfunction

  function automatic void applyOp(input logic [2:0] op, input logic [W-1:0] old,
                                  input logic [W-1:0] d, input logic [W-1:0] c,
                                  output logic [W-1:0] nw, output logic wr, output logic ok);
    nw = d; wr = 1'b0; ok = 1'b1;
    case (op)
      3'd1: wr = 1'b1;
      3'd2: begin wr = 1'b1; nw = 1; end
      3'd3: wr = 1'b1;
      3'd4: begin wr = (old == c); ok = wr; end
      3'd5: begin wr = 1'b1; nw = old + 1; end
      default: wr = 1'b0;
    endcase
  endfunction

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
    // R3: no grant in the cycle after an acceptance
    if (lastAccCyc == cyc - 1)
      check(reqReady == '0, "R3", "grant during modify", W'(reqReady), 0);
    // responses
    for (int i = 0; i < NA; i++) begin
      if (rspValid[i]) begin
        if (pCnt[i] == 0) begin
          check(1'b0, "R4", "unexpected response", W'(i), 0);
        end else begin
          int h;
          h = pHead[i];
          check(cyc == pCyc[i][h] + 2, "R4", "response latency", W'(cyc - pCyc[i][h]), 2);
          check(rspData[i*W +: W] == pData[i][h], pTag[i][h], "old word (R11 order)",
                rspData[i*W +: W], pData[i][h]);
          check(rspOk[i] == pOk[i][h], pTag[i][h], "success bit", W'(rspOk[i]), W'(pOk[i][h]));
          if (countTas && pOpQ[i][h] == 3'd2 && rspData[i*W +: W] == 0) tasZeroSeen++;
          pHead[i] = (h + 1) % QD;
          pCnt[i]--;
        end
      end
    end
    // drop valid of agents accepted at the previous edge
    for (int i = 0; i < NA; i++)
      if (justAcc[i]) begin reqValid[i] = 1'b0; justAcc[i] = 0; end
    // random generator
    for (int i = 0; i < NA; i++) begin
      if (randomLeft > 0 && !stHave[i] && !reqValid[i] && pCnt[i] < QD - 1
          && ($urandom % 3) != 0) begin
        logic [AW-1:0] a;
        a = AW'($urandom % 4);
        stHave[i] = 1;
        stOp[i]   = 3'($urandom % 8);
        stAddr[i] = a;
        stData[i] = ($urandom % 2) ? W'($urandom % 4) : W'($urandom);
        stCmp[i]  = ($urandom % 2) ? model[a] : W'($urandom % 3);
        stTag[i]  = opTag(stOp[i]);
        randomLeft--;
      end
    end
    // issue staged requests
    for (int i = 0; i < NA; i++) begin
      if (stHave[i] && !reqValid[i]) begin
        reqOp[i*3 +: 3]    = stOp[i];
        reqAddr[i*AW +: AW] = stAddr[i];
        reqData[i*W +: W]  = stData[i];
        reqCmp[i*W +: W]   = stCmp[i];
        reqValid[i] = 1'b1;
        stHave[i] = 0;
        pTag[i][(pHead[i] + pCnt[i]) % QD] = stTag[i];
      end
    end
    #1;
    // acceptance at the coming edge
    if (|reqReady) begin
      int j, expJ, t;
      logic [W-1:0] nw;
      logic wr, ok;
      logic [2:0] op;
      logic [AW-1:0] ad;
      j = 0;
      for (int i = 0; i < NA; i++) if (reqReady[i]) j = i;
      expJ = -1;
      for (int k = 1; k <= NA; k++)
        if (expJ < 0 && reqValid[(lastGrant + k) % NA]) expJ = (lastGrant + k) % NA;
      check(j == expJ && $countones(reqReady) == 1, "R2", "round-robin pick", W'(reqReady), W'(1 << expJ));
      op = reqOp[j*3 +: 3];
      ad = reqAddr[j*AW +: AW];
      applyOp(op, model[ad], reqData[j*W +: W], reqCmp[j*W +: W], nw, wr, ok);
      t = (pHead[j] + pCnt[j]) % QD;
      pData[j][t] = model[ad];
      pOk[j][t]   = ok;
      pCyc[j][t]  = cyc;
      pOpQ[j][t]  = op;
      pCnt[j]++;
      if (wr) model[ad] = nw;
      justAcc[j] = 1;
      lastGrant = j;
      lastAccCyc = cyc;
    end
  endtask

  task automatic put(input int i, input logic [2:0] op, input logic [AW-1:0] a,
                     input logic [W-1:0] d, input logic [W-1:0] c, input string tag);
    while (stHave[i]) step();
    stHave[i] = 1; stOp[i] = op; stAddr[i] = a; stData[i] = d; stCmp[i] = c; stTag[i] = tag;
  endtask

  task automatic drain();
    bit busy;
    busy = 1;
    while (busy) begin
      step();
      busy = (randomLeft > 0);
      for (int i = 0; i < NA; i++)
        if (stHave[i] || reqValid[i] || pCnt[i] != 0) busy = 1;
    end
    step(); step();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    for (int i = 0; i < NA; i++) begin
      stHave[i] = 0; justAcc[i] = 0; pHead[i] = 0; pCnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(reqReady == '0, "R1", "ready in reset", W'(reqReady), 0);
    check(rspValid == '0, "R1", "response in reset", W'(rspValid), 0);
    rst = 1'b0;
    step();
    check(reqReady == '0, "R1", "ready with no request", W'(reqReady), 0);
    check(rspValid == '0, "R1", "response with no request", W'(rspValid), 0);

    // R1: every word reads zero after reset
    for (int a = 0; a < DEPTH; a++) put(a % NA, 3'd0, AW'(a), 0, 0, "R1");
    drain();

    // R7: four-way test-and-set race on a free word
    countTas = 1; tasZeroSeen = 0;
    for (int i = 0; i < NA; i++) put(i, 3'd2, 0, 0, 0, "R7");
    drain();
    countTas = 0;
    check(tasZeroSeen == 1, "R7", "winners of the race", W'(tasZeroSeen), 1);

    // R6: release with store zero, then acquire again
    put(1, 3'd1, 0, 0, 0, "R6");
    drain();
    countTas = 1; tasZeroSeen = 0;
    put(2, 3'd2, 0, 0, 0, "R6");
    drain();
    countTas = 0;
    check(tasZeroSeen == 1, "R6", "acquire after release", W'(tasZeroSeen), 1);

    // R9: compare-and-swap, one match and one miss
    put(0, 3'd1, 3, 32'h55, 0, "R6");
    drain();
    put(1, 3'd4, 3, 32'hAA, 32'h55, "R9");
    drain();
    put(2, 3'd4, 3, 32'h77, 32'h55, "R9");
    drain();
    put(3, 3'd0, 3, 0, 0, "R9");
    drain();

    // R8: swap, R5: unused opcodes
    put(0, 3'd3, 5, 32'hDEAD_BEEF, 0, "R8");
    put(1, 3'd6, 5, 32'h1234, 0, "R5");
    put(2, 3'd7, 5, 32'h1234, 0, "R5");
    drain();
    put(3, 3'd0, 5, 0, 0, "R5");
    drain();

    // R10: increment wraps from all-ones
    put(0, 3'd1, 7, 32'hFFFF_FFFF, 0, "R10");
    drain();
    put(1, 3'd5, 7, 0, 0, "R10");
    drain();
    put(2, 3'd0, 7, 0, 0, "R10");
    drain();

    // R10/R11: four-way increment race, back-to-back per agent
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NA; i++) put(i, 3'd5, 8, 0, 0, "R11");
    drain();

    // random mix on four shared words
    randomLeft = 3000;
    drain();
    for (int a = 0; a < 4; a++) put(a, 3'd0, AW'(a), 0, 0, "R11");
    drain();

    finishRun();
  end

endmodule